// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps a small, fully associative set of recent virtual-to-physical page translations for 4 KB pages. A requester presents a virtual address, an access kind (read, write or execute) and the identifier of the address space that is running. One clock edge later the block reports one of four outcomes: a hit with the physical address, a miss, a page-not-present fault, or a permission fault. On a hit it also reports the entry's accessed and modified status as it stood before the access. A successful access marks the entry as referenced, and a successful write also marks it as modified.

After a miss, the page walker outside the block installs the translation through a fill port. A fill rewrites the slot that already holds the same page for the same address space. If there is no such slot, it takes the lowest free slot, and if every slot is occupied it evicts the slot under a rotating pointer. Two invalidate commands serve context switches: one drops every entry, and the other drops only the entries of one address space. Because every entry carries its address-space tag, translations of one process never hit for another.

Top module: `asid_tlb`

## Requirements
- R1: A lookup request in one cycle yields a registered response in the next cycle (rsp_valid high for exactly the cycles after a request). On a hit, rsp_paddr is the entry's frame number followed by the 12 low virtual-address bits unchanged, so page 0x5 mapped to frame 0xC turns 0x5200 into 0xC200.
- R2: A lookup hits only a slot that is occupied and whose page-number tag and address-space tag both equal the request's. When no slot matches, the response is a miss with no fault flag, a zero address and zero status bits.
- R3: When the matching slot was filled with its present bit at 0, the response raises rsp_page_fault, with rsp_hit low and no status update.
- R4: Access codes are 0 read, 1 write, 2 execute (3 is never allowed). Permission bits are bit 0 read, bit 1 write, bit 2 execute. A present entry whose bit for the access is 0 gives rsp_prot_fault, with no hit and no change to its referenced or modified bits.
- R5: On a hit, rsp_ref and rsp_dirty report the entry's bits before the access. The hit then sets the referenced bit, and a write hit also sets the modified bit.
- R6: A fill rewrites the slot that holds the same address space and page if there is one. Otherwise it takes the lowest-numbered free slot. Otherwise it evicts the slot under a rotating pointer, which starts at 0 after reset and advances by one only on an eviction. Every fill clears the referenced and modified bits.
- R7: A flush-by-identifier frees, in one cycle, exactly the slots tagged with that identifier, and other address spaces keep their entries.
- R8: A flush-all frees every slot in one cycle.
- R9: A fill presented in a cycle with either flush command is dropped. A lookup in that cycle sees the contents from before the flush.
- R10: A fill and a lookup of the same page in the same cycle give a miss, and the same lookup one cycle later hits.
- R11: After reset every slot is free and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute |
| req_asid | input | ASID_W | Address space of the request |
| req_vaddr | input | VPN_W+12 | Virtual address |
| fill_valid | input | 1 | Install a translation |
| fill_asid | input | ASID_W | Address-space tag of the new entry |
| fill_vpn | input | VPN_W | Virtual page number of the new entry |
| fill_pfn | input | PFN_W | Physical frame number of the new entry |
| fill_present | input | 1 | Page is resident in memory |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flush_all | input | 1 | Free every slot |
| flush_asid_valid | input | 1 | Free the slots of one address space |
| flush_asid | input | ASID_W | Address space to free |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_page_fault | output | 1 | Matching entry is not present |
| rsp_prot_fault | output | 1 | Access not permitted |
| rsp_paddr | output | PFN_W+12 | Physical address on a hit |
| rsp_dirty | output | 1 | Modified bit before this access |
| rsp_ref | output | 1 | Referenced bit before this access |

## Verification
The hardest state to reach is a full array in which the rotating victim pointer has moved. The pointer only advances when all sixteen slots are occupied and a new page arrives, and no port shows which slot was evicted. The stimulus first clears the array, then fills it with sixteen distinct pages of one address space and installs extra pages one at a time. After each extra page it probes which earlier page vanished and which survived. A refill of a page that is already resident is placed between two evictions, which shows that a rewrite neither evicts anything nor moves the pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned OFF_W = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    localparam int unsigned PERM_R = 0;
    localparam int unsigned PERM_W = 1;
    localparam int unsigned PERM_X = 2;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int unsigned N      = 16,
    parameter int unsigned ASID_W = 4,
    parameter int unsigned VPN_W  = 20
) (
    input  logic [N-1:0]             slot_valid,
    input  logic [N-1:0][ASID_W-1:0] slot_asid,
    input  logic [N-1:0][VPN_W-1:0]  slot_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    input  logic [VPN_W-1:0]         key_vpn,
    output logic [N-1:0]             match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = slot_valid[g]
                        && (slot_asid[g] == key_asid)
                        && (slot_vpn[g] == key_vpn);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [N-1:0]     slot_valid,
    input  logic [N-1:0]     same_page,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output logic             evict
);
    logic found_same;
    logic found_free;

    always_comb begin
        slot       = rr_ptr;
        found_same = 1'b0;
        found_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found_same && same_page[i]) begin
                slot       = IDX_W'(i);
                found_same = 1'b1;
            end
        end
        if (!found_same) begin
            for (int i = 0; i < N; i++) begin
                if (!found_free && !slot_valid[i]) begin
                    slot       = IDX_W'(i);
                    found_free = 1'b1;
                end
            end
        end
        evict = !found_same && !found_free;
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic       matched,
    input  logic       present,
    input  logic [2:0] perm,
    input  acc_e       acc,
    output logic       hit,
    output logic       page_fault,
    output logic       prot_fault
);
    logic allowed;

    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = perm[PERM_R];
            ACC_WRITE: allowed = perm[PERM_W];
            ACC_EXEC:  allowed = perm[PERM_X];
            default:   allowed = 1'b0;
        endcase
        page_fault = matched && !present;
        prot_fault = matched && present && !allowed;
        hit        = matched && present && allowed;
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned N      = 16,
    parameter int unsigned ASID_W = 4,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PFN_W  = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [1:0]              req_acc,
    input  logic [ASID_W-1:0]       req_asid,
    input  logic [VPN_W+OFF_W-1:0]  req_vaddr,
    input  logic                    fill_valid,
    input  logic [ASID_W-1:0]       fill_asid,
    input  logic [VPN_W-1:0]        fill_vpn,
    input  logic [PFN_W-1:0]        fill_pfn,
    input  logic                    fill_present,
    input  logic [2:0]              fill_perm,
    input  logic                    flush_all,
    input  logic                    flush_asid_valid,
    input  logic [ASID_W-1:0]       flush_asid,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_page_fault,
    output logic                    rsp_prot_fault,
    output logic [PFN_W+OFF_W-1:0]  rsp_paddr,
    output logic                    rsp_dirty,
    output logic                    rsp_ref
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned VA_W  = VPN_W + OFF_W;
    localparam int unsigned PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        logic [N-1:0]             valid;
        logic [N-1:0]             present;
        logic [N-1:0][2:0]        perm;
        logic [N-1:0]             dirty;
        logic [N-1:0]             refd;
        logic [N-1:0][ASID_W-1:0] asid;
        logic [N-1:0][VPN_W-1:0]  vpn;
        logic [N-1:0][PFN_W-1:0]  pfn;
        logic [IDX_W-1:0]         rr;
        logic                     o_valid;
        logic                     o_hit;
        logic                     o_pf;
        logic                     o_prot;
        logic [PA_W-1:0]          o_pa;
        logic                     o_dirty;
        logic                     o_ref;
    } st_t;

    st_t st_d, st_q;

    logic [N-1:0]     lk_match;
    logic [N-1:0]     fl_match;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] fl_slot;
    logic             fl_evict;
    logic             lk_hit, lk_pf, lk_prot;
    logic             flush_any;
    acc_e             acc;

    assign acc       = acc_e'(req_acc);
    assign flush_any = flush_all || flush_asid_valid;

    tlb_match #(.N(N), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lk_match (
        .slot_valid (st_q.valid),
        .slot_asid  (st_q.asid),
        .slot_vpn   (st_q.vpn),
        .key_asid   (req_asid),
        .key_vpn    (req_vaddr[VA_W-1:OFF_W]),
        .match      (lk_match)
    );

    tlb_match #(.N(N), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_fl_match (
        .slot_valid (st_q.valid),
        .slot_asid  (st_q.asid),
        .slot_vpn   (st_q.vpn),
        .key_asid   (fill_asid),
        .key_vpn    (fill_vpn),
        .match      (fl_match)
    );

    tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .slot_valid (st_q.valid),
        .same_page  (fl_match),
        .rr_ptr     (st_q.rr),
        .slot       (fl_slot),
        .evict      (fl_evict)
    );

    always_comb begin
        lk_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) lk_idx = IDX_W'(i);
        end
    end

    tlb_perm u_perm (
        .matched    (|lk_match),
        .present    (st_q.present[lk_idx]),
        .perm       (st_q.perm[lk_idx]),
        .acc        (acc),
        .hit        (lk_hit),
        .page_fault (lk_pf),
        .prot_fault (lk_prot)
    );

    always_comb begin
        st_d = st_q;

        // response of this cycle's lookup, taken from the current contents
        st_d.o_valid = req_valid;
        st_d.o_hit   = req_valid && lk_hit;
        st_d.o_pf    = req_valid && lk_pf;
        st_d.o_prot  = req_valid && lk_prot;
        st_d.o_pa    = '0;
        st_d.o_dirty = 1'b0;
        st_d.o_ref   = 1'b0;
        if (req_valid && lk_hit) begin
            st_d.o_pa    = {st_q.pfn[lk_idx], req_vaddr[OFF_W-1:0]};
            st_d.o_dirty = st_q.dirty[lk_idx];
            st_d.o_ref   = st_q.refd[lk_idx];
            st_d.refd[lk_idx] = 1'b1;
            if (acc == ACC_WRITE) st_d.dirty[lk_idx] = 1'b1;
        end

        // install, unless a flush owns this cycle
        if (fill_valid && !flush_any) begin
            st_d.valid[fl_slot]   = 1'b1;
            st_d.present[fl_slot] = fill_present;
            st_d.perm[fl_slot]    = fill_perm;
            st_d.dirty[fl_slot]   = 1'b0;
            st_d.refd[fl_slot]    = 1'b0;
            st_d.asid[fl_slot]    = fill_asid;
            st_d.vpn[fl_slot]     = fill_vpn;
            st_d.pfn[fl_slot]     = fill_pfn;
            if (fl_evict) begin
                st_d.rr = (st_q.rr == IDX_W'(N - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end

        if (flush_all) begin
            st_d.valid = '0;
        end else if (flush_asid_valid) begin
            for (int i = 0; i < N; i++) begin
                if (st_q.asid[i] == flush_asid) st_d.valid[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid      = st_q.o_valid;
    assign rsp_hit        = st_q.o_hit;
    assign rsp_page_fault = st_q.o_pf;
    assign rsp_prot_fault = st_q.o_prot;
    assign rsp_paddr      = st_q.o_pa;
    assign rsp_dirty      = st_q.o_dirty;
    assign rsp_ref        = st_q.o_ref;

    assert_resp_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_resp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lk_hit) |=> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
    assert_outcome_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_page_fault, rsp_prot_fault}) <= 1);
    assert_unique_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_any) |=> (st_q.valid != '0));
    assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (st_q.valid == '0));

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_flush_asid_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_asid_valid && st_q.asid[g] == flush_asid) |=> !st_q.valid[g]);
        assert_no_status_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && lk_match[g] && !lk_hit && !fill_valid)
            |=> $stable(st_q.dirty[g]) && $stable(st_q.refd[g]));
    end
endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_acc = '0;
    logic [3:0]  req_asid = '0;
    logic [31:0] req_vaddr = '0;
    logic        fill_valid = 1'b0;
    logic [3:0]  fill_asid = '0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_present = 1'b0;
    logic [2:0]  fill_perm = '0;
    logic        flush_all = 1'b0;
    logic        flush_asid_valid = 1'b0;
    logic [3:0]  flush_asid = '0;
    logic        rsp_valid, rsp_hit, rsp_page_fault, rsp_prot_fault;
    logic [31:0] rsp_paddr;
    logic        rsp_dirty, rsp_ref;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    asid_tlb dut (.*);

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  acc;
        logic [3:0]  asid;
        logic [31:0] va;
        logic        hit;
        logic        pf;
        logic        pr;
        logic [31:0] pa;
        logic        dirty;
        logic        refb;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{4'd1, 2'd0, 4'd1, 32'h0000_5200, 1'b1, 1'b0, 1'b0, 32'h0000_C200, 1'b0, 1'b0},
        '{4'd2, 2'd0, 4'd2, 32'h0000_5FFF, 1'b1, 1'b0, 1'b0, 32'h0007_7FFF, 1'b0, 1'b0},
        '{4'd4, 2'd1, 4'd2, 32'h0000_5000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0},
        '{4'd5, 2'd1, 4'd1, 32'h0000_5004, 1'b1, 1'b0, 1'b0, 32'h0000_C004, 1'b0, 1'b1},
        '{4'd5, 2'd0, 4'd1, 32'h0000_5008, 1'b1, 1'b0, 1'b0, 32'h0000_C008, 1'b1, 1'b1},
        '{4'd2, 2'd0, 4'd3, 32'h0000_5000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        '{4'd3, 2'd0, 4'd1, 32'h0001_0123, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        '{4'd4, 2'd2, 4'd1, 32'h0003_0ABC, 1'b1, 1'b0, 1'b0, 32'hABCD_EABC, 1'b0, 1'b0},
        '{4'd4, 2'd0, 4'd1, 32'h0003_0000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0},
        '{4'd2, 2'd0, 4'd1, 32'h0009_9000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        '{4'd4, 2'd0, 4'd2, 32'h0000_5000, 1'b1, 1'b0, 1'b0, 32'h0007_7000, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one lookup, then compare {hit,pf,prot,pa,dirty,ref} with the response
    task automatic look(input string tag, input logic [1:0] a, input logic [3:0] s,
                        input logic [31:0] va, input logic h, input logic pf,
                        input logic pr, input logic [31:0] pa, input logic d,
                        input logic r);
        @(negedge clk);
        req_valid = 1'b1; req_acc = a; req_asid = s; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, {rsp_valid, rsp_hit, rsp_page_fault, rsp_prot_fault, rsp_paddr, rsp_dirty, rsp_ref},
                 {1'b1, h, pf, pr, pa, d, r});
    endtask

    task automatic fill(input logic [3:0] s, input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic pres, input logic [2:0] perm);
        @(negedge clk);
        fill_valid = 1'b1; fill_asid = s; fill_vpn = vpn; fill_pfn = pfn;
        fill_present = pres; fill_perm = perm;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state of the response outputs
        chk("R11 reset outputs", {rsp_valid, rsp_hit, rsp_page_fault, rsp_prot_fault, rsp_paddr, rsp_dirty, rsp_ref}, '0);
        look("R11 empty after reset", 2'd0, 4'd1, 32'h0000_5200, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);

        fill(4'd1, 20'h00005, 20'h0000C, 1'b1, 3'b011);
        fill(4'd2, 20'h00005, 20'h00077, 1'b1, 3'b001);
        fill(4'd1, 20'h00010, 20'h00020, 1'b0, 3'b111);
        fill(4'd1, 20'h00030, 20'hABCDE, 1'b1, 3'b100);

        // table walk covers R1 R2 R3 R4 R5
        for (int i = 0; i < 11; i++) begin
            look($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].acc, VECS[i].asid, VECS[i].va,
                 VECS[i].hit, VECS[i].pf, VECS[i].pr, VECS[i].pa, VECS[i].dirty, VECS[i].refb);
        end

        // R7: flush address space 1 only
        @(negedge clk); flush_asid_valid = 1'b1; flush_asid = 4'd1;
        @(negedge clk); flush_asid_valid = 1'b0;
        look("R7 flushed space misses", 2'd0, 4'd1, 32'h0000_5000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        look("R7 other space kept", 2'd0, 4'd2, 32'h0000_5000, 1'b1, 1'b0, 1'b0, 32'h0007_7000, 1'b0, 1'b1);

        // R9: fill dropped in a flush cycle; lookup sees old contents
        @(negedge clk);
        flush_asid_valid = 1'b1; flush_asid = 4'd7;
        fill_valid = 1'b1; fill_asid = 4'd2; fill_vpn = 20'h00040; fill_pfn = 20'h00041;
        fill_present = 1'b1; fill_perm = 3'b111;
        @(negedge clk);
        flush_asid_valid = 1'b0; fill_valid = 1'b0;
        look("R9 fill dropped during flush", 2'd0, 4'd2, 32'h0004_0000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);

        @(negedge clk);
        flush_all = 1'b1; req_valid = 1'b1; req_acc = 2'd0; req_asid = 4'd2; req_vaddr = 32'h0000_5010;
        @(negedge clk);
        flush_all = 1'b0; req_valid = 1'b0;
        chk("R9 lookup in flush cycle sees old entry", {rsp_hit, rsp_paddr}, {1'b1, 32'h0007_7010});
        look("R8 flush all removes entry", 2'd0, 4'd2, 32'h0000_5000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);

        // R10: fill and lookup of the same page in one cycle
        @(negedge clk);
        fill_valid = 1'b1; fill_asid = 4'd5; fill_vpn = 20'h00050; fill_pfn = 20'h00123;
        fill_present = 1'b1; fill_perm = 3'b001;
        req_valid = 1'b1; req_acc = 2'd0; req_asid = 4'd5; req_vaddr = 32'h0005_0444;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0;
        chk("R10 same-cycle lookup misses", {rsp_valid, rsp_hit}, {1'b1, 1'b0});
        look("R10 next lookup hits", 2'd0, 4'd5, 32'h0005_0444, 1'b1, 1'b0, 1'b0, 32'h0012_3444, 1'b0, 1'b0);

        // R6: placement and round-robin eviction
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
        for (int i = 0; i < 16; i++) fill(4'd3, 20'h00100 + 20'(i), 20'h00400 + 20'(i), 1'b1, 3'b111);
        look("R6 last free slot used", 2'd0, 4'd3, 32'h0010_F000, 1'b1, 1'b0, 1'b0, 32'h0040_F000, 1'b0, 1'b0);
        fill(4'd3, 20'h00200, 20'h00500, 1'b1, 3'b111);
        look("R6 pointer 0 evicted", 2'd0, 4'd3, 32'h0010_0000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        look("R6 new page present", 2'd0, 4'd3, 32'h0020_0000, 1'b1, 1'b0, 1'b0, 32'h0050_0000, 1'b0, 1'b0);
        fill(4'd3, 20'h00201, 20'h00501, 1'b1, 3'b111);
        look("R6 pointer 1 evicted", 2'd0, 4'd3, 32'h0010_1000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        look("R6 slot 2 survives", 2'd0, 4'd3, 32'h0010_2000, 1'b1, 1'b0, 1'b0, 32'h0040_2000, 1'b0, 1'b0);
        look("R5 write sets modified", 2'd1, 4'd3, 32'h0010_5000, 1'b1, 1'b0, 1'b0, 32'h0040_5000, 1'b0, 1'b0);
        fill(4'd3, 20'h00105, 20'h00600, 1'b1, 3'b111);
        look("R6 refill rewrites and clears status", 2'd0, 4'd3, 32'h0010_5000, 1'b1, 1'b0, 1'b0, 32'h0060_0000, 1'b0, 1'b0);
        look("R6 refill evicts nothing", 2'd0, 4'd3, 32'h0020_1000, 1'b1, 1'b0, 1'b0, 32'h0050_1000, 1'b0, 1'b0);
        fill(4'd3, 20'h00202, 20'h00502, 1'b1, 3'b111);
        look("R6 pointer 2 evicted", 2'd0, 4'd3, 32'h0010_2000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        look("R6 slot 3 survives", 2'd0, 4'd3, 32'h0010_3000, 1'b1, 1'b0, 1'b0, 32'h0040_3000, 1'b0, 1'b0);
        look("R4 access code 3 refused", 2'd3, 4'd3, 32'h0010_3000, 1'b0, 1'b0, 1'b1, '0, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule